// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the host-facing half of an SPI master. It holds the configuration words that a separate serial engine reads (enable, clock setup, transmit and receive word formats, frame setup). It also holds two word FIFOs that both sit behind one data offset, and a small set of event flags that can raise an interrupt. The host reaches everything through a plain 32-bit register bus in which reads are combinational and writes take effect at the clock edge. The serial engine takes words out of the transmit FIFO, hands received words back, and reports each finished word and its busy state.

A write to the data offset queues a word for transmission, and a read of the same offset returns the oldest received word. Software flushes either FIFO by writing a one to a bit that is not stored. Event flags are cleared by writing ones to the clear offset. While the enable is clear, the engine sees no word to send and its pop requests do nothing.

Top module: `spi_regfront`

## Requirements
- R1: After reset every configuration register, the flags and both FIFOs are zero or empty, `irq` is 0, and status (0x14) reads 0x20.
- R2: The configuration registers read back their writable bits, masked as follows: control 0x00 with bit 0; clock 0x04 with mask 0x70FF; transmit format 0x08 with 0x3FFF; receive format 0x0C with 0xFF; frame 0x10 with 0xC000; interrupt enable 0x18 with 0x19; FIFO control 0x20 with 0x0F0F.
- R3: A write to 0x24 appends `reg_wdata` to an 8-entry transmit FIFO, which the engine sees in order on `eng_tx_data`. A write while the FIFO holds 8 words is ignored, even if the engine pops in the same cycle.
- R4: A read of 0x24 returns the oldest received word and removes it. A read while the receive FIFO is empty returns 0 and removes nothing.
- R5: Status bit 7 mirrors `eng_busy`, bit 5 is 1 while the transmit FIFO holds fewer than 8 words, bit 0 is 1 while the receive FIFO holds any word, and all other bits read 0.
- R6: `eng_tx_valid` is 1 exactly when control bit 0 is set and the transmit FIFO is not empty. With control bit 0 clear, `eng_tx_pop` removes nothing.
- R7: Writing FIFO control with bit 12 set empties the transmit FIFO, and with bit 4 set empties the receive FIFO, at that clock edge. These two bits always read 0. Bits 11:8 hold the transmit threshold and bits 3:0 hold the receive threshold.
- R8: A received word pushed while the receive FIFO holds 8 words is dropped and sets the overrun flag (bit 0 of 0x1C). A push in the same cycle as a receive flush is dropped without setting the flag.
- R9: The receive-complete flag (bit 3) sets when a pushed word is accepted and the resulting level is at or above the receive threshold. The transmit-complete flag (bit 4) sets when `eng_word_done` is 1 while the transmit level is at or below the transmit threshold.
- R10: Reading 0x1C returns the flags in bits 4, 3 and 0. Writing ones there clears the matching flags, zeros leave them alone, and a flag being set in the same cycle stays set.
- R11: `irq` is 1 exactly when some flag is set whose matching bit in 0x18 (bit 4, 3 or 0) is also set.
- R12: Reads of unmapped offsets return 0, and writes to status or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 0x24) |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| eng_tx_valid | output | 1 | A word is available for the engine |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine takes the transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_word_done | input | 1 | Engine finished shifting one word |
| eng_busy | input | 1 | Engine is mid-transfer |
| cfg_enable | output | 1 | Control enable bit |
| cfg_clock | output | 32 | Clock setup register |
| cfg_txfmt | output | 32 | Transmit word format register |
| cfg_rxfmt | output | 32 | Receive word format register |
| cfg_frame | output | 32 | Frame setup register |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the transmit FIFO past its depth and writes more words while the engine is held off. A design that wraps its pointer would corrupt the oldest word or report a full FIFO as empty. It reads the receive FIFO past empty: a design that pops anyway would shift garbage into later reads instead of returning 0. It injects a word into a full receive FIFO and checks that the overrun flag is set and that no stored word is disturbed. It then clears a flag in the same cycle that the flag is set again, which catches a design where the clear wins. Flushes are issued with words in both FIFOs, and the FIFO control register is read back afterwards, so that a flush bit that was stored, or that failed to empty a FIFO, shows up in status or in the read-back value.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

  // register offsets (bytes)
  localparam int OFF_CTL  = 'h00;
  localparam int OFF_CLK  = 'h04;
  localparam int OFF_TXF  = 'h08;
  localparam int OFF_RXF  = 'h0C;
  localparam int OFF_FRM  = 'h10;
  localparam int OFF_STAT = 'h14;
  localparam int OFF_IE   = 'h18;
  localparam int OFF_ICLR = 'h1C;
  localparam int OFF_FCTL = 'h20;
  localparam int OFF_DATA = 'h24;

  // writable bit masks
  localparam logic [31:0] MSK_CTL  = 32'h0000_0001;
  localparam logic [31:0] MSK_CLK  = 32'h0000_70FF;
  localparam logic [31:0] MSK_TXF  = 32'h0000_3FFF;
  localparam logic [31:0] MSK_RXF  = 32'h0000_00FF;
  localparam logic [31:0] MSK_FRM  = 32'h0000_C000;
  localparam logic [31:0] MSK_IE   = 32'h0000_0019;
  localparam logic [31:0] MSK_FCTL = 32'h0000_0F0F;

  // bit positions the engine side / software depend on
  localparam int BIT_TXFLUSH = 12;
  localparam int BIT_RXFLUSH = 4;
  localparam int BIT_TXC     = 4;
  localparam int BIT_RXC     = 3;
  localparam int BIT_OVR     = 0;

  // internal flag vector order: [2] tx complete, [1] rx complete, [0] overrun
  typedef logic [2:0] flag_vec_t;

  function automatic flag_vec_t flags_from_word(logic [31:0] w);
    return {w[BIT_TXC], w[BIT_RXC], w[BIT_OVR]};
  endfunction

  function automatic logic [31:0] flags_to_word(flag_vec_t f);
    logic [31:0] w;
    w = '0;
    w[BIT_TXC] = f[2];
    w[BIT_RXC] = f[1];
    w[BIT_OVR] = f[0];
    return w;
  endfunction

  // sticky flag update: set beats clear
  function automatic flag_vec_t flag_update(flag_vec_t cur, flag_vec_t set, flag_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  // FIFO level after one cycle of pop/push
  function automatic int unsigned level_after(int unsigned cnt, logic pop, logic push);
    return cnt - {31'd0, pop} + {31'd0, push};
  endfunction

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= CW'(spi_regfront_pkg::level_after(32'(count), do_pop, do_push));
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq
  import spi_regfront_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  input  flag_vec_t en_vec,
  output flag_vec_t flags,
  output logic      irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_update(flags, set_vec, clr_vec);
  end

  assign irq = |(flags & en_vec);

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_word_done,
  input  logic              eng_busy,
  output logic              cfg_enable,
  output logic [31:0]       cfg_clock,
  output logic [31:0]       cfg_txfmt,
  output logic [31:0]       cfg_rxfmt,
  output logic [31:0]       cfg_frame,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);

  // decoded accesses
  logic wr_ctl, wr_clk, wr_txf, wr_rxf, wr_frm, wr_ie, wr_iclr, wr_fctl, wr_data, rd_data;

  function automatic logic at(logic [ADDR_W-1:0] a, int off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_ctl  = reg_wr & at(reg_addr, OFF_CTL);
  assign wr_clk  = reg_wr & at(reg_addr, OFF_CLK);
  assign wr_txf  = reg_wr & at(reg_addr, OFF_TXF);
  assign wr_rxf  = reg_wr & at(reg_addr, OFF_RXF);
  assign wr_frm  = reg_wr & at(reg_addr, OFF_FRM);
  assign wr_ie   = reg_wr & at(reg_addr, OFF_IE);
  assign wr_iclr = reg_wr & at(reg_addr, OFF_ICLR);
  assign wr_fctl = reg_wr & at(reg_addr, OFF_FCTL);
  assign wr_data = reg_wr & at(reg_addr, OFF_DATA);
  assign rd_data = reg_rd & ~reg_wr & at(reg_addr, OFF_DATA);

  // configuration storage
  logic [31:0] r_ctl, r_clk, r_txf, r_rxf, r_frm, r_ie, r_fctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_ctl  <= '0;
      r_clk  <= '0;
      r_txf  <= '0;
      r_rxf  <= '0;
      r_frm  <= '0;
      r_ie   <= '0;
      r_fctl <= '0;
    end else begin
      if (wr_ctl)  r_ctl  <= reg_wdata & MSK_CTL;
      if (wr_clk)  r_clk  <= reg_wdata & MSK_CLK;
      if (wr_txf)  r_txf  <= reg_wdata & MSK_TXF;
      if (wr_rxf)  r_rxf  <= reg_wdata & MSK_RXF;
      if (wr_frm)  r_frm  <= reg_wdata & MSK_FRM;
      if (wr_ie)   r_ie   <= reg_wdata & MSK_IE;
      if (wr_fctl) r_fctl <= reg_wdata & MSK_FCTL;
    end
  end

  // named internal events
  logic        cfg_en;
  logic        tx_flush, rx_flush;
  logic        tx_push_req, tx_pop_req, rx_pop_req;
  logic [3:0]  tx_thr, rx_thr;
  logic        rx_accept, rx_ovr_evt, rx_done_evt, tx_done_evt;
  logic [DATA_W-1:0] tx_dout, rx_dout;
  logic [CW-1:0]     tx_count, rx_count;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  flag_vec_t   flags, set_vec, clr_vec, ie_bits;

  assign cfg_en      = r_ctl[0];
  assign tx_flush    = wr_fctl & reg_wdata[BIT_TXFLUSH];
  assign rx_flush    = wr_fctl & reg_wdata[BIT_RXFLUSH];
  assign tx_thr      = r_fctl[11:8];
  assign rx_thr      = r_fctl[3:0];
  assign tx_push_req = wr_data;
  assign tx_pop_req  = eng_tx_pop & cfg_en;
  assign rx_pop_req  = rd_data;

  spi_rf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push_req), .pop(tx_pop_req), .din(reg_wdata[DATA_W-1:0]),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  spi_rf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(eng_rx_push), .pop(rx_pop_req), .din(eng_rx_data),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  // event generation
  assign rx_accept   = eng_rx_push & ~rx_full & ~rx_flush;
  assign rx_ovr_evt  = eng_rx_push & rx_full & ~rx_flush;
  assign rx_done_evt = rx_accept &
                       (level_after(32'(rx_count), rx_pop_req & ~rx_empty, 1'b1) >= 32'(rx_thr));
  assign tx_done_evt = eng_word_done & (32'(tx_count) <= 32'(tx_thr));

  assign set_vec = {tx_done_evt, rx_done_evt, rx_ovr_evt};
  assign clr_vec = wr_iclr ? flags_from_word(reg_wdata) : '0;
  assign ie_bits = flags_from_word(r_ie);

  spi_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_vec(ie_bits), .flags(flags), .irq(irq)
  );

  // read mux
  logic [31:0] status_w;
  always_comb begin
    status_w    = '0;
    status_w[7] = eng_busy;
    status_w[5] = ~tx_full;
    status_w[0] = ~rx_empty;
  end

  always_comb begin
    reg_rdata = '0;
    if      (at(reg_addr, OFF_CTL))  reg_rdata = r_ctl;
    else if (at(reg_addr, OFF_CLK))  reg_rdata = r_clk;
    else if (at(reg_addr, OFF_TXF))  reg_rdata = r_txf;
    else if (at(reg_addr, OFF_RXF))  reg_rdata = r_rxf;
    else if (at(reg_addr, OFF_FRM))  reg_rdata = r_frm;
    else if (at(reg_addr, OFF_STAT)) reg_rdata = status_w;
    else if (at(reg_addr, OFF_IE))   reg_rdata = r_ie;
    else if (at(reg_addr, OFF_ICLR)) reg_rdata = flags_to_word(flags);
    else if (at(reg_addr, OFF_FCTL)) reg_rdata = r_fctl;
    else if (at(reg_addr, OFF_DATA)) reg_rdata = rx_empty ? '0 : 32'(rx_dout);
  end

  // engine side
  assign eng_tx_valid = cfg_en & ~tx_empty;
  assign eng_tx_data  = tx_dout;
  assign cfg_enable   = cfg_en;
  assign cfg_clock    = r_clk;
  assign cfg_txfmt    = r_txf;
  assign cfg_rxfmt    = r_rxf;
  assign cfg_frame    = r_frm;

endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          tx_wr_req,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          rx_push,
  input logic          rx_rd_req,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic [2:0]    flags,
  input logic [2:0]    ie_bits,
  input logic          irq
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_req && tx_count == CW'(DEPTH) && !cfg_en) |=> tx_count == CW'(DEPTH));

  assert_disabled_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !tx_wr_req && !tx_flush) |=> tx_count == $past(tx_count));

  assert_tx_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_count == '0);

  assert_rx_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == '0);

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count == CW'(DEPTH) && !rx_flush) |=> flags[0]);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_req && rx_count == '0 && !rx_push) |=> rx_count == '0);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_bits == 3'b000) |-> !irq);

endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .tx_wr_req(tx_push_req),
  .tx_flush(tx_flush), .rx_flush(rx_flush), .rx_push(eng_rx_push),
  .rx_rd_req(rx_pop_req), .tx_count(tx_count), .rx_count(rx_count),
  .flags(flags), .ie_bits(ie_bits), .irq(irq)
);

// File: tb/spi_regfront_tb_top.sv
module spi_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_tx_valid, eng_tx_pop, eng_rx_push, eng_word_done;
  logic [31:0] eng_tx_data, eng_rx_data;
  logic        eng_busy = 1'b0;
  logic        cfg_enable, irq;
  logic [31:0] cfg_clock, cfg_txfmt, cfg_rxfmt, cfg_frame;

  logic        stub_on = 1'b0, inj_push = 1'b0;
  logic [31:0] inj_data = '0;
  logic        loop;

  always #2.5 clk = ~clk;   // 200 MHz

  // loopback stand-in for the serial engine
  assign loop          = stub_on & eng_tx_valid;
  assign eng_tx_pop    = loop;
  assign eng_word_done = loop;
  assign eng_rx_push   = loop | inj_push;
  assign eng_rx_data   = loop ? eng_tx_data : inj_data;

  spi_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_valid(eng_tx_valid),
    .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_word_done(eng_word_done), .eng_busy(eng_busy),
    .cfg_enable(cfg_enable), .cfg_clock(cfg_clock), .cfg_txfmt(cfg_txfmt),
    .cfg_rxfmt(cfg_rxfmt), .cfg_frame(cfg_frame), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] txq[$], rxq[$];
  logic [31:0] m_ctl, m_clk, m_txf, m_rxf, m_frm, m_ie, m_fc, m_flags;
  logic        s_wr, s_rd, s_pop, s_push, s_done;
  logic [7:0]  s_addr;
  logic [31:0] s_wdata, s_rxd;

  function automatic logic [31:0] mdl_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_ctl;
      8'h04: return m_clk;
      8'h08: return m_txf;
      8'h0C: return m_rxf;
      8'h10: return m_frm;
      8'h14: return {24'd0, eng_busy, 1'b0, txq.size() < 8, 4'd0, rxq.size() > 0};
      8'h18: return m_ie;
      8'h1C: return m_flags;
      8'h20: return m_fc;
      8'h24: return (rxq.size() > 0) ? rxq[0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_ctl = 0; m_clk = 0; m_txf = 0; m_rxf = 0; m_frm = 0; m_ie = 0; m_fc = 0; m_flags = 0;
    end else begin
      int tsz, rsz, lvl;
      bit tfl, rfl, tpop, tpush, rpop, racc, ovr, rdone, tdone;
      logic [31:0] clr, set;
      tsz   = txq.size();
      rsz   = rxq.size();
      tfl   = s_wr && s_addr == 8'h20 && s_wdata[12];
      rfl   = s_wr && s_addr == 8'h20 && s_wdata[4];
      tpop  = s_pop && m_ctl[0] && tsz > 0;
      tpush = s_wr && s_addr == 8'h24 && tsz < 8;
      rpop  = s_rd && !s_wr && s_addr == 8'h24 && rsz > 0;
      racc  = s_push && rsz < 8 && !rfl;
      ovr   = s_push && rsz >= 8 && !rfl;
      lvl   = rsz - int'(rpop) + 1;
      rdone = racc && lvl >= int'(m_fc[3:0]);
      tdone = s_done && tsz <= int'(m_fc[11:8]);
      if (tfl) txq.delete();
      else begin
        if (tpop)  void'(txq.pop_front());
        if (tpush) txq.push_back(s_wdata);
      end
      if (rfl) rxq.delete();
      else begin
        if (rpop) void'(rxq.pop_front());
        if (racc) rxq.push_back(s_rxd);
      end
      set = {27'd0, tdone, rdone, 2'b00, ovr};
      clr = (s_wr && s_addr == 8'h1C) ? (s_wdata & 32'h19) : 32'd0;
      m_flags = (m_flags & ~clr) | set;
      if (s_wr) case (s_addr)
        8'h00: m_ctl = s_wdata & 32'h1;
        8'h04: m_clk = s_wdata & 32'h70FF;
        8'h08: m_txf = s_wdata & 32'h3FFF;
        8'h0C: m_rxf = s_wdata & 32'hFF;
        8'h10: m_frm = s_wdata & 32'hC000;
        8'h18: m_ie  = s_wdata & 32'h19;
        8'h20: m_fc  = s_wdata & 32'h0F0F;
        default: ;
      endcase
    end
  end

  // per-cycle comparison, then snapshot of the inputs for the coming edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(irq === ((m_flags & m_ie) != 0), "R11 irq", {31'd0, irq}, {31'd0, (m_flags & m_ie) != 0});
      chk(eng_tx_valid === (m_ctl[0] && txq.size() > 0), "R6 tx_valid",
          {31'd0, eng_tx_valid}, {31'd0, m_ctl[0] && txq.size() > 0});
      if (txq.size() > 0)
        chk(eng_tx_data === txq[0], "R3 tx_data order", eng_tx_data, txq[0]);
    end
    s_wr = reg_wr; s_rd = reg_rd; s_addr = reg_addr; s_wdata = reg_wdata;
    s_pop = eng_tx_pop; s_push = eng_rx_push; s_done = eng_word_done; s_rxd = eng_rx_data;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 e = mdl_rd(a);
    chk(reg_rdata === e, tag, reg_rdata, e);
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic inj(input logic [31:0] d);
    @(negedge clk); inj_push = 1; inj_data = d;
    @(posedge clk); #1 inj_push = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2);
    // R1 reset state
    rd_chk(8'h14, "R1 status after reset");
    chk(reg_rdata === 32'h20, "R1 status literal", reg_rdata, 32'h20);
    for (int i = 0; i < 10; i++) rd_chk(8'(i*4), "R1 reset read");
    chk(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);

    // R2 masks, R7 flush bits read 0, R12 unmapped and status writes
    for (int i = 0; i < 9; i++) if (i != 5 && i != 7) wr(8'(i*4), 32'hFFFF_FFFF);
    for (int i = 0; i < 9; i++) rd_chk(8'(i*4), "R2 readback mask");
    rd_chk(8'h20, "R7 flush bits read 0");
    wr(8'h14, 32'h0); wr(8'h28, 32'hFFFF_FFFF);
    rd_chk(8'h14, "R12 status write ignored");
    rd_chk(8'h28, "R12 unmapped reads 0");
    rd_chk(8'h3C, "R12 unmapped reads 0");
    wr(8'h00, 0); wr(8'h18, 0);

    // R6 disabled: words queue, engine pops ignored
    stub_on = 1;
    for (int i = 0; i < 3; i++) wr(8'h24, 32'hA500_0000 + 32'(i));
    idle(4);
    rd_chk(8'h14, "R6 status while disabled");
    rd_chk(8'h24, "R4 empty read returns 0");
    rd_chk(8'h14, "R4 empty read popped nothing");
    // R3 overfill
    for (int i = 3; i < 9; i++) wr(8'h24, 32'hA500_0000 + 32'(i));
    rd_chk(8'h14, "R5 tx full clears bit 5");

    // R9 thresholds and loopback
    wr(8'h18, 32'h19);
    wr(8'h20, 32'h0108);
    wr(8'h00, 32'h1);
    idle(15);
    rd_chk(8'h1C, "R9 tx and rx complete flags");
    chk(reg_rdata === 32'h18, "R9 flags literal", reg_rdata, 32'h18);
    rd_chk(8'h14, "R5 rx not empty, tx not full");

    // R8 overrun
    inj(32'hDEAD_BEEF);
    rd_chk(8'h1C, "R8 overrun flag");
    chk(reg_rdata === 32'h19, "R8 flags literal", reg_rdata, 32'h19);

    // R10 clear
    wr(8'h1C, 32'h08);
    rd_chk(8'h1C, "R10 write one clears");
    wr(8'h1C, 32'h0);
    rd_chk(8'h1C, "R10 write zero keeps");

    // R4 drain in order
    for (int i = 0; i < 8; i++) rd_chk(8'h24, "R4 rx order");
    rd_chk(8'h24, "R4 empty read returns 0");
    rd_chk(8'h14, "R5 status after drain");

    // R11 masking
    wr(8'h18, 32'h0);
    idle(2);
    chk(irq === 1'b0, "R11 all masked", {31'd0, irq}, 0);
    wr(8'h18, 32'h01);
    idle(2);
    chk(irq === 1'b1, "R11 overrun enabled", {31'd0, irq}, 1);

    // R7 flush with data in both FIFOs
    wr(8'h00, 0);
    for (int i = 0; i < 4; i++) wr(8'h24, 32'h5A00_0000 + 32'(i));
    inj(32'h1111_0001); inj(32'h1111_0002);
    rd_chk(8'h14, "R7 both FIFOs hold data");
    wr(8'h20, 32'h0000_1118);
    rd_chk(8'h14, "R7 both FIFOs flushed");
    chk(reg_rdata === 32'h20, "R7 status literal", reg_rdata, 32'h20);
    rd_chk(8'h20, "R7 thresholds kept, flush bits 0");
    rd_chk(8'h24, "R7 flushed rx reads 0");

    // R5 busy mirror
    eng_busy = 1;
    rd_chk(8'h14, "R5 busy bit");
    eng_busy = 0;

    // R10 set and clear in the same cycle; R9 with rx threshold 0
    wr(8'h20, 32'h0100);
    wr(8'h1C, 32'h19);
    rd_chk(8'h1C, "R10 all cleared");
    @(negedge clk);
    inj_push = 1; inj_data = 32'h7777_0000;
    reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 32'h08;
    @(posedge clk); #1 inj_push = 0; reg_wr = 0;
    rd_chk(8'h1C, "R10 set beats clear");
    chk(reg_rdata[3] === 1'b1, "R10 rx complete held", reg_rdata, 32'h08);
    rd_chk(8'h24, "R9 word at threshold 0");

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule